// File: doc/BRIEF.md
# Cache Allocation Control Register

This block holds the 64-bit configuration word of a 4-way set-associative second-level cache. It also makes the allocation decision that this word drives. Software reaches the word through a simple register port at one fixed address. Each write lands on the next clock edge. Reads are combinational and return zero for any other address.

A miss request enters with two tags: whether it comes from the instruction side or the data side, and whether it is an I/O or MSR access. In the same cycle the block answers with four outputs:

- whether the line is allocated or the miss bypasses the cache;
- a one-hot victim way, chosen by a 2-bit round-robin pointer that skips the ways locked for the requesting side;
- a redirect-to-cache enable;
- static control levels, such as force-dirty-eviction.

Writing the invalidate bit produces a whole-cache invalidate pulse of one cycle and stores nothing.

A two-state machine produces that pulse.

- State `ST_IDLE` is the normal state. The transition `idle_to_inval` fires on a decoded write with bit 4 set.
- State `ST_INVAL` drives the pulse for exactly one cycle.
- Leaving `ST_INVAL`, the transition `inval_to_idle` fires when no new invalidating write is present. The transition `inval_rearm` stays in `ST_INVAL` when a new invalidating write arrives in that same cycle.

Top module: `cache_alloc_ctrl`

## Requirements
- R1: After reset, a read at address 0x1920 returns 0x0000_0000_0000_000E. A read at any other address returns 0, and a write to any other address leaves the register unchanged.
- R2: Bits 63:24, 15:9 and 4 always read 0. A write ignores these bits. All other bits (23:16, 8:5, 3:0) read back the value last written.
- R3: An instruction-side allocation never selects a way whose bit is 1 in the instruction lock mask, bits 23:20 (bit 20+i locks way i).
- R4: A data-side allocation never selects a way whose bit is 1 in the data lock mask, bits 19:16 (bit 16+i locks way i).
- R5: A valid miss allocates only when all five of these hold:
  - bit 0 (cache enable) is set;
  - bit 1 (global allocation enable) is set;
  - the enable for its source is set: bit 3 for the instruction side, bit 2 for the data side;
  - the miss is not bypassed under R10;
  - at least one way is unlocked for its side.
  Otherwise `miss_bypass` is asserted instead.
- R6: While bit 0 is clear, `miss_alloc` and `redirect_en` stay low for every miss.
- R7: A write to 0x1920 with bit 4 set makes `inval_pulse` high for exactly the one cycle after the write edge.
- R8: If all four ways are locked for the requesting side, the miss bypasses and `victim_way` is 0.
- R9: The victim is the first unlocked way at or after the round-robin pointer, in increasing order modulo 4. `victim_way` is one-hot with bit i for way i. The pointer resets to 0 and advances by one, modulo 4, after each allocation.
- R10: With bit 7 set, a miss marked as I/O or MSR neither allocates nor asserts `redirect_en`. With bit 7 clear, such a miss is handled like any other.
- R11: `force_dirty_evict`, `wait_dm_writes` and `tag_clk_gate_en` follow bits 6, 5 and 8 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational |
| miss_valid | input | 1 | A miss request is present |
| miss_instr | input | 1 | 1 = instruction side, 0 = data side |
| miss_io | input | 1 | Request is an I/O or MSR access |
| miss_alloc | output | 1 | Allocate the line |
| miss_bypass | output | 1 | Serve the miss without allocating |
| victim_way | output | 4 | One-hot victim way |
| redirect_en | output | 1 | Route this access to the cache |
| inval_pulse | output | 1 | Whole-cache invalidate, one cycle |
| force_dirty_evict | output | 1 | Treat data-side evictions as dirty |
| wait_dm_writes | output | 1 | Wait for all data-side write beats |
| tag_clk_gate_en | output | 1 | Tag clock-gating enable |

## Verification
The bench has a directed part and a random part.

Directed cases:
- They cover reset readback, writes to a foreign address, and an all-ones write. The all-ones write separates stored bits from reserved bits and from the write-only bit.
- They run a fixed lock mask across successive allocations. This shows the pointer moving and skipping locked ways.
- They run fully locked masks and each disable bit on its own, so that every bypass cause is seen alone.

Random part:
- Random configuration words are mixed with random miss source and I/O tag.
- Instruction-side and data-side masks differ, so a design that swaps the two masks or enables is caught.

// File: rtl/cac_pkg.sv
package cac_pkg;
    localparam logic [63:0] CFG_RESET = 64'h0000_0000_0000_000E;
    localparam logic [63:0] CFG_WMASK = 64'h0000_0000_00FF_01EF;

    localparam int B_CACHE_EN  = 0;
    localparam int B_ALLOC_ALL = 1;
    localparam int B_ALLOC_DAT = 2;
    localparam int B_ALLOC_INS = 3;
    localparam int B_INVAL     = 4;
    localparam int B_WAIT_DMW  = 5;
    localparam int B_DIRTY_EV  = 6;
    localparam int B_PASS_IO   = 7;
    localparam int B_TAG_GATE  = 8;
    localparam int B_DLOCK_LO  = 16;
    localparam int B_ILOCK_LO  = 20;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_INVAL = 1'b1
    } inval_state_e;
endpackage

// File: rtl/cac_cfg_reg.sv
module cac_cfg_reg
    import cac_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1920
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic [63:0]       cfg,
    output logic              inval_pulse
);
    logic         hit;
    logic         inval_req;
    logic [63:0]  cfg_q;
    inval_state_e state_q, state_d;

    assign hit       = (reg_addr == REG_ADDR);
    assign inval_req = reg_wr && hit && reg_wdata[B_INVAL];

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (reg_wr && hit)
            cfg_q <= reg_wdata & CFG_WMASK;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        inval_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (inval_req)
                    state_d = ST_INVAL;   // idle_to_inval
            end
            ST_INVAL: begin
                inval_pulse = 1'b1;
                if (inval_req)
                    state_d = ST_INVAL;   // inval_rearm
                else
                    state_d = ST_IDLE;    // inval_to_idle
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cfg       = cfg_q;
    assign reg_rdata = hit ? cfg_q : 64'd0;
endmodule

// File: rtl/cac_victim_sel.sv
module cac_victim_sel #(
    parameter int WAYS  = 4,
    parameter int PTR_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  lock,
    input  logic [PTR_W-1:0] ptr,
    output logic [WAYS-1:0]  victim,
    output logic             any_free
);
    logic [WAYS-1:0] free_rot;
    logic [WAYS-1:0] pick_rot;

    // Rotate the free-way vector so that the pointer's way sits at index 0
    for (genvar k = 0; k < WAYS; k++) begin : g_rot
        assign free_rot[k] = ~lock[(k + int'(ptr)) % WAYS];
    end

    // Lowest set bit of the rotated vector
    assign pick_rot = free_rot & (~free_rot + 1'b1);

    // Rotate back to way numbering
    for (genvar w = 0; w < WAYS; w++) begin : g_unrot
        assign victim[w] = pick_rot[(w - int'(ptr) + WAYS) % WAYS];
    end

    assign any_free = |free_rot;
endmodule

// File: rtl/cac_alloc_dec.sv
module cac_alloc_dec
    import cac_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int PTR_W = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [63:0]     cfg,
    input  logic            miss_valid,
    input  logic            miss_instr,
    input  logic            miss_io,
    output logic            miss_alloc,
    output logic            miss_bypass,
    output logic [WAYS-1:0] victim_way,
    output logic            redirect_en
);
    logic [PTR_W-1:0] ptr_q;
    logic [WAYS-1:0]  lock;
    logic [WAYS-1:0]  cand;
    logic             any_free;
    logic             src_en;
    logic             passed;

    assign lock   = miss_instr ? cfg[B_ILOCK_LO +: WAYS] : cfg[B_DLOCK_LO +: WAYS];
    assign src_en = miss_instr ? cfg[B_ALLOC_INS] : cfg[B_ALLOC_DAT];
    assign passed = miss_io && cfg[B_PASS_IO];

    cac_victim_sel #(.WAYS(WAYS), .PTR_W(PTR_W)) u_sel (
        .lock     (lock),
        .ptr      (ptr_q),
        .victim   (cand),
        .any_free (any_free)
    );

    assign miss_alloc  = miss_valid && cfg[B_CACHE_EN] && cfg[B_ALLOC_ALL]
                         && src_en && !passed && any_free;
    assign miss_bypass = miss_valid && !miss_alloc;
    assign victim_way  = miss_alloc ? cand : '0;
    assign redirect_en = miss_valid && cfg[B_CACHE_EN] && !passed;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (miss_alloc)
            ptr_q <= ptr_q + 1'b1;
    end
endmodule

// File: rtl/cache_alloc_ctrl.sv
module cache_alloc_ctrl
    import cac_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1920,
    parameter int                WAYS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              miss_valid,
    input  logic              miss_instr,
    input  logic              miss_io,
    output logic              miss_alloc,
    output logic              miss_bypass,
    output logic [WAYS-1:0]   victim_way,
    output logic              redirect_en,
    output logic              inval_pulse,
    output logic              force_dirty_evict,
    output logic              wait_dm_writes,
    output logic              tag_clk_gate_en
);
    localparam int PTR_W = $clog2(WAYS);

    logic [63:0] cfg;

    cac_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cfg         (cfg),
        .inval_pulse (inval_pulse)
    );

    cac_alloc_dec #(.WAYS(WAYS), .PTR_W(PTR_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .miss_valid  (miss_valid),
        .miss_instr  (miss_instr),
        .miss_io     (miss_io),
        .miss_alloc  (miss_alloc),
        .miss_bypass (miss_bypass),
        .victim_way  (victim_way),
        .redirect_en (redirect_en)
    );

    assign force_dirty_evict = cfg[B_DIRTY_EV];
    assign wait_dm_writes    = cfg[B_WAIT_DMW];
    assign tag_clk_gate_en   = cfg[B_TAG_GATE];
endmodule

// File: rtl/cac_checks.sv
module cac_checks #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1920
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [63:0]       reg_wdata,
    input logic [63:0]       reg_rdata,
    input logic              miss_valid,
    input logic              miss_instr,
    input logic              miss_alloc,
    input logic              miss_bypass,
    input logic [3:0]        victim_way,
    input logic              redirect_en,
    input logic              inval_pulse,
    input logic [63:0]       cfg,
    input logic [1:0]        ptr
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~64'h0000_0000_00FF_01EF) == 64'd0);

    p_ilock_respected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_alloc && miss_instr) |-> ((victim_way & cfg[23:20]) == 4'd0));

    p_dlock_respected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_alloc && !miss_instr) |-> ((victim_way & cfg[19:16]) == 4'd0));

    p_alloc_xor_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (miss_alloc != miss_bypass));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[0] |-> (!miss_alloc && !redirect_en));

    p_inval_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_ADDR && reg_wdata[4]) |=> inval_pulse);

    p_inval_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |-> $past(reg_wr && reg_addr == REG_ADDR && reg_wdata[4]));

    p_victim_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_alloc |-> ($countones(victim_way) == 1));

    p_no_victim_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_alloc |-> (victim_way == 4'd0));

    p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_alloc |=> (ptr == $past(ptr) + 2'd1));
endmodule

bind cache_alloc_ctrl cac_checks #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .miss_valid  (miss_valid),
    .miss_instr  (miss_instr),
    .miss_alloc  (miss_alloc),
    .miss_bypass (miss_bypass),
    .victim_way  (victim_way),
    .redirect_en (redirect_en),
    .inval_pulse (inval_pulse),
    .cfg         (cfg),
    .ptr         (u_dec.ptr_q)
);

// File: tb/tb_cache_alloc_ctrl.sv
module tb_cache_alloc_ctrl;
    localparam logic [15:0] A_CFG = 16'h1920;
    localparam logic [63:0] WMASK = 64'h0000_0000_00FF_01EF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        miss_valid = 1'b0, miss_instr = 1'b0, miss_io = 1'b0;
    logic        miss_alloc, miss_bypass, redirect_en, inval_pulse;
    logic        force_dirty_evict, wait_dm_writes, tag_clk_gate_en;
    logic [3:0]  victim_way;

    int          n_chk = 0, n_bad = 0;
    logic [63:0] m_cfg = 64'hE;
    logic [1:0]  m_ptr = 2'd0;

    always #4 clk = ~clk;   // 125 MHz

    cache_alloc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miss_valid(miss_valid),
        .miss_instr(miss_instr), .miss_io(miss_io), .miss_alloc(miss_alloc),
        .miss_bypass(miss_bypass), .victim_way(victim_way), .redirect_en(redirect_en),
        .inval_pulse(inval_pulse), .force_dirty_evict(force_dirty_evict),
        .wait_dm_writes(wait_dm_writes), .tag_clk_gate_en(tag_clk_gate_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] f_victim(input logic [3:0] lock, input logic [1:0] p);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] w;
            w = p + 2'(k);
            if (!lock[w]) return 4'(1) << w;
        end
        return 4'd0;
    endfunction

    task automatic rd_check(input logic [15:0] a, input logic [63:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == A_CFG) m_cfg = d & WMASK;
        #1 chk("R7 pulse", 64'(inval_pulse), 64'(a == A_CFG && d[4]));
        chk("R11 dirty", 64'(force_dirty_evict), 64'(m_cfg[6]));
        chk("R11 waitdm", 64'(wait_dm_writes), 64'(m_cfg[5]));
        chk("R11 taggate", 64'(tag_clk_gate_en), 64'(m_cfg[8]));
    endtask

    task automatic miss(input logic ins, input logic io);
        logic [3:0] lk;
        logic       en, pass, a;
        @(negedge clk);
        miss_valid = 1'b1; miss_instr = ins; miss_io = io;
        lk   = ins ? m_cfg[23:20] : m_cfg[19:16];
        en   = ins ? m_cfg[3] : m_cfg[2];
        pass = io && m_cfg[7];
        a    = m_cfg[0] && m_cfg[1] && en && !pass && (lk != 4'hF);
        #1;
        chk("R5 alloc", 64'(miss_alloc), 64'(a));
        chk("R5 bypass", 64'(miss_bypass), 64'(!a));
        chk("R9 victim", 64'(victim_way), 64'(a ? f_victim(lk, m_ptr) : 4'd0));
        chk("R10 redirect", 64'(redirect_en), 64'(m_cfg[0] && !pass));
        chk("R7 no pulse", 64'(inval_pulse), 64'd0);
        if (a) m_ptr = m_ptr + 2'd1;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1920));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state and decode
        rd_check(A_CFG, 64'hE, "R1 reset");
        rd_check(16'h1921, 64'd0, "R1 other addr");
        miss(1'b0, 1'b0);                          // R6 cache disabled after reset
        chk("R6 no alloc", 64'(miss_alloc), 64'd0);
        wr(16'h1900, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_check(A_CFG, 64'hE, "R1 foreign write ignored");

        // R2 all-ones: reserved and bit 4 dropped, R7 pulse
        wr(A_CFG, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_check(A_CFG, WMASK, "R2 readback");
        @(negedge clk) #1 chk("R7 single cycle", 64'(inval_pulse), 64'd0);

        // R8 everything locked both sides
        miss(1'b1, 1'b0);
        miss(1'b0, 1'b0);
        miss(1'b1, 1'b1);                          // R10 passthrough

        // R3 and R9: instruction locks way 1 and 2, data locks way 0
        wr(A_CFG, 64'h0000_0000_0061_000F);
        for (int i = 0; i < 6; i++) miss(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) miss(1'b0, 1'b0);  // R4
        // R5 each enable alone
        wr(A_CFG, 64'h0000_0000_0000_000D);          // global alloc off
        miss(1'b1, 1'b0);
        wr(A_CFG, 64'h0000_0000_0000_0007);          // instr alloc off
        miss(1'b1, 1'b0);
        miss(1'b0, 1'b0);
        wr(A_CFG, 64'h0000_0000_0000_000B);          // data alloc off
        miss(1'b0, 1'b0);
        miss(1'b1, 1'b0);
        wr(A_CFG, 64'h0000_0000_0000_008F);          // R10 pass io
        miss(1'b0, 1'b1);
        miss(1'b0, 1'b0);

        // Random configurations
        for (int i = 0; i < 300; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            if ($urandom_range(3) != 0) d[1:0] = 2'b11;
            wr(A_CFG, d);
            rd_check(A_CFG, d & WMASK, "R2 random readback");
            for (int j = 0; j < 6; j++) miss(1'($urandom), 1'($urandom_range(3) == 0));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule